// File: doc/BRIEF.md
# Pushbutton Power Sequencing Controller

This block is the digital sequencer of a power-management device. One active-low pushbutton drives it, together with an external-power-present flag and a buck-enable request. It steps through seven states: hard reset, off, two power-up states, on, and two power-down states. It drives the regulator enables, a debounced active-low button-status output and a filtered power-good flag. The button is decoded by how long it is held. A medium hold is reported on the status output. A longer hold from off or hard reset starts power-up. A very long hold while powered forces a shutdown into hard reset.

All durations are counted in ticks of a free-running tick-enable input, and every duration is a parameter. A system can therefore pick its own time base, and a simulation can use short windows. Regulation status comes in as one digital flag per regulator. Power-good considers only the regulators that are currently enabled.

Top module: `pbseq_ctrl`

## Requirements
- R1: After reset the state output reads 1 (off), status is high, all enables are low and power-good is low. State codes are: 0 hard reset, 1 off, 2 power-up by button, 3 power-up by external power, 4 on, 5 power-down by button, 6 power-down by request.
- R2: The button passes through a two-flop synchronizer. Any return to high restarts every press-duration count, so short presses separated by releases never add up.
- R3: In state 0 or 1, a button held low for T_PUP ticks enters state 2. After a forced shutdown, the button must first be released before a press can count.
- R4: In state 0 or 1, external power present for T_EXT consecutive ticks enters state 3. A qualifying button press takes priority.
- R5: State 2 or 3 lasts T_PUPD ticks and then moves to state 4.
- R6: In state 1, the buck request held high for T_PONUP ticks enters state 4 directly. In an on state entered this way, a low request moves to state 6 on the next clock, and the enables drop at that edge.
- R7: States 5 and 6 last T_PDN ticks. State 5 then moves to state 0, and state 6 moves to state 1.
- R8: In state 2, 3 or 4, a button held low for T_HR ticks enters state 5.
- R9: The status output goes low once the button has been held T_STAT ticks, and only in states 2, 3 and 4. In any other state it is high.
- R10: Once low, the status output stays low for at least T_PW ticks. It returns high only when, in addition, the button has been high for T_REL ticks.
- R11: The enables are all high in states 2, 3 and 4 and all low in every other state.
- R12: Power-good rises once every enabled regulator has reported in-regulation for T_PG ticks. It falls on the next clock when any enabled regulator drops out, or when none is enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Time-base enable, one cycle per tick |
| btn_n | input | 1 | Pushbutton, active low, asynchronous |
| ext_pwr | input | 1 | External power present |
| buck_req | input | 1 | Buck enable request |
| reg_ok | input | NREG | Per-regulator in-regulation flags |
| stat_n | output | 1 | Button status, active low |
| reg_en | output | NREG | Regulator enables |
| pgood | output | 1 | Filtered power-good |
| state_o | output | 3 | Current state code |

## Verification
The bench holds the button continuously from a power-up through the forced shutdown and on into hard reset. A design that forgot the release interlock would then power straight back up, and one that let short presses accumulate would start power-up from bursts of taps. It drops the buck request while in the on state, where a slow path would keep the enables high for extra cycles. The status release is exercised both before and after the minimum width has elapsed, and a regulator is dropped while power-good is high. A design that filtered the falling edge, or counted disabled regulators, would then report power-good for too long.

// File: rtl/pbseq_pkg.sv
package pbseq_pkg;

    typedef enum logic [2:0] {
        ST_HRST = 3'd0,
        ST_OFF  = 3'd1,
        ST_UPB  = 3'd2,
        ST_UPX  = 3'd3,
        ST_ON   = 3'd4,
        ST_DNB  = 3'd5,
        ST_DNR  = 3'd6
    } pstate_e;

    function automatic logic st_live(pstate_e s);
        return (s == ST_UPB) || (s == ST_UPX) || (s == ST_ON);
    endfunction

endpackage

// File: rtl/pbseq_sync.sv
module pbseq_sync #(
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    typedef struct packed {
        logic s1;
        logic s2;
    } sync_t;

    sync_t sync_d, sync_q;

    always_comb begin
        sync_d    = sync_q;
        sync_d.s1 = din;
        sync_d.s2 = sync_q.s1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= '{s1: RST_VAL, s2: RST_VAL};
        end else begin
            sync_q <= sync_d;
        end
    end

    assign dout = sync_q.s2;
endmodule

// File: rtl/pbseq_satcnt.sv
module pbseq_satcnt #(
    parameter int CW    = 18,
    parameter int LIMIT = 100
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          clr,
    output logic [CW-1:0] cnt
);
    localparam logic [CW-1:0] LIM_C = CW'(LIMIT);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clr) begin
            cnt_d = '0;
        end else if (tick && (cnt_q < LIM_C)) begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign cnt = cnt_q;

    // R2: count never passes its saturation value
    p_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LIM_C);

    // R2: a clear request empties the count by the next edge
    p_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (cnt_q == '0));
endmodule

// File: rtl/pbseq_status.sv
module pbseq_status #(
    parameter int CW     = 18,
    parameter int T_STAT = 500,
    parameter int T_PW   = 500,
    parameter int T_REL  = 9
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          active,
    input  logic          btn_low,
    input  logic [CW-1:0] press_cnt,
    output logic          stat_low
);
    localparam logic [CW-1:0] STAT_C = CW'(T_STAT);
    localparam logic [CW-1:0] PW_C   = CW'(T_PW);
    localparam logic [CW-1:0] REL_C  = CW'(T_REL);

    typedef struct packed {
        logic          low;
        logic [CW-1:0] wcnt;
        logic [CW-1:0] rcnt;
    } stat_t;

    stat_t stat_d, stat_q;

    always_comb begin
        stat_d = stat_q;
        if (!active) begin
            stat_d = '0;
        end else if (!stat_q.low) begin
            if (press_cnt >= STAT_C) begin
                stat_d.low  = 1'b1;
                stat_d.wcnt = '0;
                stat_d.rcnt = '0;
            end
        end else begin
            if (tick && (stat_q.wcnt < PW_C)) begin
                stat_d.wcnt = stat_q.wcnt + 1'b1;
            end
            if (btn_low) begin
                stat_d.rcnt = '0;
            end else if (tick && (stat_q.rcnt < REL_C)) begin
                stat_d.rcnt = stat_q.rcnt + 1'b1;
            end
            if ((stat_q.wcnt >= PW_C) && (stat_q.rcnt >= REL_C)) begin
                stat_d = '0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stat_q <= '0;
        end else begin
            stat_q <= stat_d;
        end
    end

    assign stat_low = stat_q.low;

    // R10: while powered, a low pulse ends only after the minimum width
    p_min_width_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(stat_q.low) && $past(active)) |-> ($past(stat_q.wcnt) >= PW_C));

    // R10: a held button keeps the status low
    p_held_low_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_q.low && btn_low && active) |=> stat_q.low);
endmodule

// File: rtl/pbseq_pgood.sv
module pbseq_pgood #(
    parameter int NREG = 3,
    parameter int CW   = 18,
    parameter int T_PG = 118
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            tick,
    input  logic [NREG-1:0] en,
    input  logic [NREG-1:0] ok,
    output logic            pgood
);
    localparam logic [CW-1:0] PG_C = CW'(T_PG);

    typedef struct packed {
        logic          pg;
        logic [CW-1:0] gcnt;
    } pg_t;

    pg_t pg_d, pg_q;
    logic all_ok;

    assign all_ok = (|en) && (&(ok | ~en));

    always_comb begin
        pg_d = pg_q;
        if (!all_ok) begin
            pg_d = '0;
        end else begin
            if (tick && (pg_q.gcnt < PG_C)) begin
                pg_d.gcnt = pg_q.gcnt + 1'b1;
            end
            pg_d.pg = (pg_q.gcnt >= PG_C);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pg_q <= '0;
        end else begin
            pg_q <= pg_d;
        end
    end

    assign pgood = pg_q.pg;

    // R12: a regulator dropping out clears power-good at the next edge
    p_fall_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !all_ok |=> !pg_q.pg);

    // R12: power-good rises only while all enabled regulators are good
    p_rise_r12: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pg_q.pg) |-> $past(all_ok));
endmodule

// File: rtl/pbseq_ctrl.sv
module pbseq_ctrl
    import pbseq_pkg::*;
#(
    parameter int NREG    = 3,
    parameter int CW      = 18,
    parameter int T_STAT  = 500,
    parameter int T_PW    = 500,
    parameter int T_REL   = 9,
    parameter int T_PUP   = 4000,
    parameter int T_EXT   = 1000,
    parameter int T_HR    = 140000,
    parameter int T_PUPD  = 50000,
    parameter int T_PDN   = 10000,
    parameter int T_PONUP = 9,
    parameter int T_PG    = 118
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            tick,
    input  logic            btn_n,
    input  logic            ext_pwr,
    input  logic            buck_req,
    input  logic [NREG-1:0] reg_ok,
    output logic            stat_n,
    output logic [NREG-1:0] reg_en,
    output logic            pgood,
    output logic [2:0]      state_o
);
    localparam int              SLIM     = (T_PUPD > T_PDN) ? T_PUPD : T_PDN;
    localparam logic [CW-1:0]   PUP_C    = CW'(T_PUP);
    localparam logic [CW-1:0]   EXT_C    = CW'(T_EXT);
    localparam logic [CW-1:0]   HR_C     = CW'(T_HR);
    localparam logic [CW-1:0]   PUPD_C   = CW'(T_PUPD);
    localparam logic [CW-1:0]   PDN_C    = CW'(T_PDN);
    localparam logic [CW-1:0]   PONUP_C  = CW'(T_PONUP);

    typedef struct packed {
        pstate_e         st;
        logic            via;
        logic            relw;
        logic [NREG-1:0] en;
    } fsm_t;

    fsm_t fsm_d, fsm_q;

    logic          btn_s;
    logic          btn_low;
    logic          st_change;
    logic          stat_low;
    logic [CW-1:0] press_cnt;
    logic [CW-1:0] ext_cnt;
    logic [CW-1:0] req_cnt;
    logic [CW-1:0] st_cnt;

    pbseq_sync #(.RST_VAL(1'b1)) u_btn_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (btn_n),
        .dout (btn_s)
    );

    assign btn_low = !btn_s;

    pbseq_satcnt #(.CW(CW), .LIMIT(T_HR)) u_press_cnt (
        .clk  (clk),
        .rst_n(rst_n),
        .tick (tick),
        .clr  (!btn_low),
        .cnt  (press_cnt)
    );

    pbseq_satcnt #(.CW(CW), .LIMIT(T_EXT)) u_ext_cnt (
        .clk  (clk),
        .rst_n(rst_n),
        .tick (tick),
        .clr  (!ext_pwr),
        .cnt  (ext_cnt)
    );

    pbseq_satcnt #(.CW(CW), .LIMIT(T_PONUP)) u_req_cnt (
        .clk  (clk),
        .rst_n(rst_n),
        .tick (tick),
        .clr  (!buck_req),
        .cnt  (req_cnt)
    );

    pbseq_satcnt #(.CW(CW), .LIMIT(SLIM)) u_state_cnt (
        .clk  (clk),
        .rst_n(rst_n),
        .tick (tick),
        .clr  (st_change),
        .cnt  (st_cnt)
    );

    always_comb begin
        fsm_d = fsm_q;
        unique case (fsm_q.st)
            ST_HRST, ST_OFF: begin
                if ((press_cnt >= PUP_C) && !fsm_q.relw) begin
                    fsm_d.st = ST_UPB;
                end else if (ext_cnt >= EXT_C) begin
                    fsm_d.st = ST_UPX;
                end else if ((fsm_q.st == ST_OFF) && (req_cnt >= PONUP_C)) begin
                    fsm_d.st  = ST_ON;
                    fsm_d.via = 1'b1;
                end
            end
            ST_UPB, ST_UPX: begin
                if (press_cnt >= HR_C) begin
                    fsm_d.st = ST_DNB;
                end else if (st_cnt >= PUPD_C) begin
                    fsm_d.st  = ST_ON;
                    fsm_d.via = 1'b0;
                end
            end
            ST_ON: begin
                if (press_cnt >= HR_C) begin
                    fsm_d.st = ST_DNB;
                end else if (fsm_q.via && !buck_req) begin
                    fsm_d.st = ST_DNR;
                end
            end
            ST_DNB: begin
                if (st_cnt >= PDN_C) begin
                    fsm_d.st = ST_HRST;
                end
            end
            ST_DNR: begin
                if (st_cnt >= PDN_C) begin
                    fsm_d.st = ST_OFF;
                end
            end
            default: fsm_d.st = ST_OFF;
        endcase

        if (fsm_q.st == ST_DNB) begin
            fsm_d.relw = 1'b1;
        end else if (!btn_low) begin
            fsm_d.relw = 1'b0;
        end

        fsm_d.en = st_live(fsm_d.st) ? '1 : '0;
    end

    assign st_change = (fsm_d.st != fsm_q.st);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fsm_q <= '{st: ST_OFF, via: 1'b0, relw: 1'b0, en: '0};
        end else begin
            fsm_q <= fsm_d;
        end
    end

    pbseq_status #(
        .CW    (CW),
        .T_STAT(T_STAT),
        .T_PW  (T_PW),
        .T_REL (T_REL)
    ) u_status (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .active   (st_live(fsm_d.st)),
        .btn_low  (btn_low),
        .press_cnt(press_cnt),
        .stat_low (stat_low)
    );

    pbseq_pgood #(
        .NREG(NREG),
        .CW  (CW),
        .T_PG(T_PG)
    ) u_pgood (
        .clk  (clk),
        .rst_n(rst_n),
        .tick (tick),
        .en   (fsm_q.en),
        .ok   (reg_ok),
        .pgood(pgood)
    );

    assign stat_n  = !stat_low;
    assign reg_en  = fsm_q.en;
    assign state_o = fsm_q.st;

    // R11: enables only in power-up and on states
    p_en_live_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (fsm_q.en != '0) |-> st_live(fsm_q.st));

    // R9: status low only while powered
    p_stat_live_r9: assert property (@(posedge clk) disable iff (!rst_n)
        stat_low |-> st_live(fsm_q.st));

    // R6: a dropped request leaves the request-entered on state at once
    p_req_drop_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ((fsm_q.st == ST_ON) && fsm_q.via && !buck_req && (press_cnt < HR_C))
        |=> (fsm_q.st == ST_DNR));

    // R8: the button power-down state is entered only after a long hold
    p_long_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ((fsm_q.st == ST_DNB) && ($past(fsm_q.st) != ST_DNB))
        |-> ($past(press_cnt) >= HR_C));

    // R3: a hold carried over from a forced shutdown cannot power up
    p_release_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ((fsm_q.st == ST_HRST) && fsm_q.relw) |=> (fsm_q.st != ST_UPB));
endmodule

// File: tb/pbseq_ctrl_bench.sv
module pbseq_ctrl_bench;
    localparam int CLK_PERIOD = 10;
    localparam int TDIV    = 4;
    localparam int NREG    = 3;
    localparam int T_STAT  = 5;
    localparam int T_PW    = 6;
    localparam int T_REL   = 2;
    localparam int T_PUP   = 8;
    localparam int T_EXT   = 4;
    localparam int T_HR    = 40;
    localparam int T_PUPD  = 20;
    localparam int T_PDN   = 10;
    localparam int T_PONUP = 3;
    localparam int T_PG    = 5;
    localparam int SLIM    = (T_PUPD > T_PDN) ? T_PUPD : T_PDN;
    localparam int ALLEN   = (1 << NREG) - 1;
    localparam int WD_CYC  = 20000;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            tick = 1'b0;
    logic            btn_n = 1'b1;
    logic            ext_pwr = 1'b0;
    logic            buck_req = 1'b0;
    logic [NREG-1:0] reg_ok = '0;
    logic            stat_n;
    logic [NREG-1:0] reg_en;
    logic            pgood;
    logic [2:0]      state_o;

    int total = 0;
    int bad   = 0;
    int tdiv  = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    always @(negedge clk) begin
        tdiv = (tdiv + 1) % TDIV;
        tick = (tdiv == 0);
    end

    pbseq_ctrl #(
        .NREG(NREG), .CW(12), .T_STAT(T_STAT), .T_PW(T_PW), .T_REL(T_REL),
        .T_PUP(T_PUP), .T_EXT(T_EXT), .T_HR(T_HR), .T_PUPD(T_PUPD),
        .T_PDN(T_PDN), .T_PONUP(T_PONUP), .T_PG(T_PG)
    ) u_pbseq_ctrl (
        .clk(clk), .rst_n(rst_n), .tick(tick), .btn_n(btn_n),
        .ext_pwr(ext_pwr), .buck_req(buck_req), .reg_ok(reg_ok),
        .stat_n(stat_n), .reg_en(reg_en), .pgood(pgood), .state_o(state_o)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // behavioural reference, one update per clock
    int bq[$];
    int m_pc, m_ec, m_rc, m_sc, m_st, m_via, m_rw;
    int m_sl, m_wc, m_rl, m_en, m_gc, m_pg;

    function automatic int up(int v, int lim, bit t);
        return (t && v < lim) ? v + 1 : v;
    endfunction

    always @(posedge clk) begin
        int low, nst, nvia, act, ok, nsl, nwc, nrl, ngc, npg;
        if (!rst_n) begin
            bq = '{1, 1};
            m_pc = 0; m_ec = 0; m_rc = 0; m_sc = 0; m_st = 1; m_via = 0;
            m_rw = 0; m_sl = 0; m_wc = 0; m_rl = 0; m_en = 0; m_gc = 0; m_pg = 0;
        end else begin
            low  = (bq[1] == 0);
            nst  = m_st;
            nvia = m_via;
            if (m_st == 0 || m_st == 1) begin
                if (m_pc >= T_PUP && m_rw == 0) nst = 2;
                else if (m_ec >= T_EXT) nst = 3;
                else if (m_st == 1 && m_rc >= T_PONUP) begin nst = 4; nvia = 1; end
            end else if (m_st == 2 || m_st == 3) begin
                if (m_pc >= T_HR) nst = 5;
                else if (m_sc >= T_PUPD) begin nst = 4; nvia = 0; end
            end else if (m_st == 4) begin
                if (m_pc >= T_HR) nst = 5;
                else if (m_via == 1 && !buck_req) nst = 6;
            end else if (m_st == 5) begin
                if (m_sc >= T_PDN) nst = 0;
            end else if (m_st == 6) begin
                if (m_sc >= T_PDN) nst = 1;
            end
            act = (nst == 2 || nst == 3 || nst == 4);
            nsl = m_sl; nwc = m_wc; nrl = m_rl;
            if (!act) begin
                nsl = 0; nwc = 0; nrl = 0;
            end else if (m_sl == 0) begin
                if (m_pc >= T_STAT) begin nsl = 1; nwc = 0; nrl = 0; end
            end else begin
                nwc = up(m_wc, T_PW, tick);
                nrl = low ? 0 : up(m_rl, T_REL, tick);
                if (m_wc >= T_PW && m_rl >= T_REL) begin nsl = 0; nwc = 0; nrl = 0; end
            end
            ok = (m_en != 0) && ((int'(reg_ok) | (~m_en & ALLEN)) == ALLEN);
            ngc = ok ? up(m_gc, T_PG, tick) : 0;
            npg = ok && (m_gc >= T_PG);
            m_rw = (m_st == 5) ? 1 : (low ? m_rw : 0);
            m_sc = (nst != m_st) ? 0 : up(m_sc, SLIM, tick);
            m_pc = low ? up(m_pc, T_HR, tick) : 0;
            m_ec = ext_pwr ? up(m_ec, T_EXT, tick) : 0;
            m_rc = buck_req ? up(m_rc, T_PONUP, tick) : 0;
            m_st = nst; m_via = nvia; m_en = act ? ALLEN : 0;
            m_sl = nsl; m_wc = nwc; m_rl = nrl; m_gc = ngc; m_pg = npg;
            bq = '{int'(btn_n), bq[0]};
        end
    end

    always @(posedge clk) begin
        #1;
        if (rst_n) begin
            check(int'(state_o) == m_st, "R3 R4 R5 R6 R7 R8 model state", int'(state_o), m_st);
            check(int'(stat_n) == (1 - m_sl), "R9 R10 model status", int'(stat_n), 1 - m_sl);
            check(int'(reg_en) == m_en, "R11 model enables", int'(reg_en), m_en);
            check(int'(pgood) == m_pg, "R12 model power-good", int'(pgood), m_pg);
        end
    end

    task automatic ticks(input int n);
        repeat (n * TDIV) @(negedge clk);
    endtask

    task automatic scenario();
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(state_o == 3'd1, "R1 reset state", state_o, 1);
        check(stat_n == 1'b1, "R1 reset status", stat_n, 1);
        check(reg_en == '0, "R1 reset enables", reg_en, 0);
        check(pgood == 1'b0, "R1 reset power-good", pgood, 0);

        // R2: two short presses do not add up
        btn_n = 1'b0; ticks(5); btn_n = 1'b1; ticks(2);
        btn_n = 1'b0; ticks(5); btn_n = 1'b1; ticks(2);
        check(state_o == 3'd1, "R2 short presses ignored", state_o, 1);

        // R6: request path to on, then drop
        buck_req = 1'b1; ticks(6);
        check(state_o == 3'd4, "R6 request reaches on", state_o, 4);
        check(reg_en == 3'd7, "R11 enables in on", reg_en, 7);
        buck_req = 1'b0;
        @(negedge clk); @(negedge clk);
        check(state_o == 3'd6, "R6 request drop powers down", state_o, 6);
        check(reg_en == '0, "R6 enables off after drop", reg_en, 0);
        ticks(12);
        check(state_o == 3'd1, "R7 request power-down returns off", state_o, 1);

        // R3: button power-up, status pulse
        btn_n = 1'b0; ticks(11);
        check(state_o == 3'd2, "R3 press powers up", state_o, 2);
        check(stat_n == 1'b0, "R9 status low on hold", stat_n, 0);
        btn_n = 1'b1; ticks(1);
        check(stat_n == 1'b0, "R10 status held for width", stat_n, 0);
        ticks(8);
        check(stat_n == 1'b1, "R10 status released", stat_n, 1);
        ticks(12);
        check(state_o == 3'd4, "R5 power-up ends in on", state_o, 4);

        // R12: power-good filter
        reg_ok = 3'd7; ticks(7);
        check(pgood == 1'b1, "R12 power-good rises", pgood, 1);
        reg_ok = 3'd3;
        @(negedge clk); @(negedge clk);
        check(pgood == 1'b0, "R12 power-good falls", pgood, 0);
        reg_ok = 3'd7;

        // R9: press below the status threshold
        btn_n = 1'b0; ticks(3); btn_n = 1'b1;
        check(stat_n == 1'b1, "R9 short press no status", stat_n, 1);
        ticks(3);

        // R8: long hold forces shutdown, held through into hard reset
        btn_n = 1'b0; ticks(44);
        check(state_o == 3'd5, "R8 long hold powers down", state_o, 5);
        check(reg_en == '0, "R11 enables off in power-down", reg_en, 0);
        check(pgood == 1'b0, "R12 no power-good when disabled", pgood, 0);
        ticks(12);
        check(state_o == 3'd0, "R7 button power-down reaches hard reset", state_o, 0);
        ticks(12);
        check(state_o == 3'd0, "R3 held button blocked after reset", state_o, 0);
        check(stat_n == 1'b1, "R9 status high in hard reset", stat_n, 1);
        btn_n = 1'b1; ticks(2);

        // R4: external power path
        ext_pwr = 1'b1; ticks(6);
        check(state_o == 3'd3, "R4 external power powers up", state_o, 3);
        ext_pwr = 1'b0; ticks(22);
        check(state_o == 3'd4, "R5 external power-up ends in on", state_o, 4);
    endtask

    initial begin
        fork
            scenario();
            begin
                repeat (WD_CYC) @(posedge clk);
                total++;
                bad++;
                $display("FAIL watchdog actual=%0d expected=0", WD_CYC);
            end
        join_any
        disable fork;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule